// File: doc/BRIEF.md
# Parallel Program Memory Bus Controller

This block turns a simple internal request/acknowledge port into cycles on an external asynchronous parallel memory bus. The bus carries three active-low device selects, a 23-bit address, a 16-bit data bus and active-low read and write strobes. Select 1 is meant for the boot flash. Selects 0 and 2 may each drive an SRAM or a flash part.

Each select has its own 5-bit wait count, set through a small configuration port. An access holds the select, the address and the strobe for (wait + 1) wait-state ticks. It then releases the bus for one cycle and acknowledges. A mode input chooses the tick rate: one tick per core clock in normal mode, or one tick per eight core clocks in low-power mode. Firmware computes the wait value as the device access time divided by the tick period, rounded up. The mode is sampled only while the bus is idle.

The two top address bits leave the block on two shared pins. Each shared pin carries either its address bit or a general-purpose output. After reset both pins are general-purpose inputs with their drivers off, so memory above 2^21 words cannot be reached until firmware switches the pins to address mode. With both pins in general-purpose mode the block suits a device of 32 Mb or less. Bit 21 in address mode suits 64 Mb, and both bits in address mode suit 128 Mb.

Top module: `pmem_ctrl`

## Requirements
- R1: After reset all three selects, the read strobe and the write strobe are high, ack_o is low, and both shared-pin drivers (pin_oe_o) are off.
- R2: A read (we_i=0) to a mapped select drives only that select low and pm_oe_no low, keeps pm_dq_oe_o low, and drives pm_addr_o with address bits 20:0. rdata_o returns the pm_dq_i value sampled on the final tick.
- R3: A write (we_i=1) drives pm_we_no low and pm_dq_oe_o high for the whole access, with pm_dq_o equal to the write data.
- R4: In normal mode (low_pwr_i=0) the select stays low for exactly wait+1 core cycles. In low-power mode it stays low for exactly (wait+1)*8 core cycles.
- R5: Config addresses 0, 1 and 2 hold the 5-bit wait count (bits 4:0) of select 0, 1 and 2 respectively. Each count applies only to its own select, and the values 0 to 31 are all accepted.
- R6: After the select rises, one cycle follows with all selects and strobes high. ack_o is then high for exactly one cycle, so the request-to-acknowledge latency is select-low cycles plus two.
- R7: At most one select is low in any cycle.
- R8: A request with cs_sel_i=3 drives no select. It is answered on the next cycle with ack_o and err_o both high.
- R9: Config address 3 is the shared-pin register: bit0/bit1 choose address mode for bit 21/22, bit2/bit3 are driver enables, and bit4/bit5 are output values. A pin in general-purpose mode follows its enable and value bits, and the address bit never reaches it.
- R10: A pin in address mode has its driver on and carries the latched address bit (21 or 22) of the current access.
- R11: The mode value present when a request is accepted governs the whole access. A change of low_pwr_i during the access does not alter its length.
- R12: Reading config address 3 returns the shared-pin inputs pin_i in bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| low_pwr_i | input | 1 | 1 selects the coarse (divide-by-8) wait tick |
| req_i | input | 1 | Access request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| cs_sel_i | input | 2 | Target select index; 3 is unmapped |
| addr_i | input | 23 | Word address |
| wdata_i | input | 16 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | High with ack_o for an unmapped select |
| rdata_o | output | 16 | Read data |
| cfg_we_i | input | 1 | Config register write strobe |
| cfg_addr_i | input | 2 | Config register index |
| cfg_wdata_i | input | 8 | Config write data |
| cfg_rdata_o | output | 8 | Config read data (combinational) |
| pm_cs_no | output | 3 | Active-low device selects |
| pm_addr_o | output | 21 | External address bits 20:0 |
| pm_oe_no | output | 1 | Active-low read strobe |
| pm_we_no | output | 1 | Active-low write strobe |
| pm_dq_o | output | 16 | Data to the device |
| pm_dq_oe_o | output | 1 | Data bus driver enable |
| pm_dq_i | input | 16 | Data from the device |
| pin_o | output | 2 | Shared pins, index 0 = bit 21, index 1 = bit 22 |
| pin_oe_o | output | 2 | Shared pin driver enables |
| pin_i | input | 2 | Shared pin inputs |

## Verification
A configuration write to a select's wait register can land on the same clock edge at which the controller accepts a request to that same select. The bench provokes this by raising cfg_we_i and req_i at the same falling edge. The access that starts must run with the old count, and the next access to that select must run with the new one; both are judged by counting the cycles in which the select is low. A change of low_pwr_i in mid-access is provoked the same way. The access length is checked to still match the mode that was sampled at acceptance.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_RECOV, ST_ACK} pm_state_e;
endpackage

// File: rtl/pmem_tick.sv
module pmem_tick #(
  parameter int LP_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic lp_i,
  output logic tick_o
);
  localparam int PW = (LP_DIV > 1) ? $clog2(LP_DIV) : 1;
  logic [PW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == PW'(LP_DIV - 1));
  assign tick_o = !lp_i || last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (last)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmem_cfg.sv
module pmem_cfg #(
  parameter int NCS = 3,
  parameter int WSW = 5,
  parameter int NSH = 2,
  parameter int CAW = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [CAW-1:0]          addr_i,
  input  logic [7:0]              wdata_i,
  input  logic [NSH-1:0]          pin_i,
  output logic [7:0]              rdata_o,
  output logic [NCS-1:0][WSW-1:0] wait_o,
  output logic [NSH-1:0]          sel_o,
  output logic [NSH-1:0]          oe_o,
  output logic [NSH-1:0]          out_o
);
  logic [NCS-1:0][WSW-1:0] wait_q;
  logic [NSH-1:0] sel_q, oe_q, out_q;
  logic hit_pin;

  assign hit_pin = (addr_i == CAW'(NCS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      sel_q  <= '0;
      oe_q   <= '0;
      out_q  <= '0;
    end else if (we_i) begin
      if (32'(addr_i) < NCS) wait_q[addr_i] <= wdata_i[WSW-1:0];
      if (hit_pin) begin
        sel_q <= wdata_i[NSH-1:0];
        oe_q  <= wdata_i[2*NSH-1:NSH];
        out_q <= wdata_i[3*NSH-1:2*NSH];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (32'(addr_i) < NCS) rdata_o = 8'(wait_q[addr_i]);
    else if (hit_pin)      rdata_o = 8'({pin_i, out_q, oe_q, sel_q});
  end

  assign wait_o = wait_q;
  assign sel_o  = sel_q;
  assign oe_o   = oe_q;
  assign out_o  = out_q;
endmodule

// File: rtl/pmem_pin_mux.sv
module pmem_pin_mux #(
  parameter int NSH = 2
) (
  input  logic [NSH-1:0] sel_i,
  input  logic [NSH-1:0] oe_i,
  input  logic [NSH-1:0] out_i,
  input  logic [NSH-1:0] addr_hi_i,
  output logic [NSH-1:0] pin_o,
  output logic [NSH-1:0] pin_oe_o
);
  for (genvar k = 0; k < NSH; k++) begin : g_pin
    assign pin_o[k]    = sel_i[k] ? addr_hi_i[k] : out_i[k];
    assign pin_oe_o[k] = sel_i[k] | oe_i[k];
  end
endmodule

// File: rtl/pmem_ctrl.sv
module pmem_ctrl
  import pmem_pkg::*;
#(
  parameter int NCS    = 3,
  parameter int AW     = 23,
  parameter int DW     = 16,
  parameter int WSW    = 5,
  parameter int LP_DIV = 8,
  parameter int NSH    = 2,
  parameter int CSW    = $clog2(NCS + 1),
  parameter int CAW    = $clog2(NCS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              low_pwr_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [CSW-1:0]    cs_sel_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [DW-1:0]     rdata_o,
  input  logic              cfg_we_i,
  input  logic [CAW-1:0]    cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  output logic [NCS-1:0]    pm_cs_no,
  output logic [AW-NSH-1:0] pm_addr_o,
  output logic              pm_oe_no,
  output logic              pm_we_no,
  output logic [DW-1:0]     pm_dq_o,
  output logic              pm_dq_oe_o,
  input  logic [DW-1:0]     pm_dq_i,
  output logic [NSH-1:0]    pin_o,
  output logic [NSH-1:0]    pin_oe_o,
  input  logic [NSH-1:0]    pin_i
);
  pm_state_e state_q;
  logic [CSW-1:0] cs_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic [WSW-1:0] cnt_q;
  logic           we_q, err_q, lp_q, busy, tick;
  logic [NCS-1:0][WSW-1:0] wait_w;
  logic [NSH-1:0] sel_w, oe_w, out_w;

  assign busy = (state_q == ST_ACCESS);

  pmem_cfg #(.NCS(NCS), .WSW(WSW), .NSH(NSH), .CAW(CAW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .pin_i, .rdata_o(cfg_rdata_o),
    .wait_o(wait_w), .sel_o(sel_w), .oe_o(oe_w), .out_o(out_w)
  );

  pmem_tick #(.LP_DIV(LP_DIV)) u_tick (
    .clk_i, .rst_ni, .clr_i(!busy), .lp_i(lp_q), .tick_o(tick)
  );

  pmem_pin_mux #(.NSH(NSH)) u_pins (
    .sel_i(sel_w), .oe_i(oe_w), .out_i(out_w),
    .addr_hi_i(addr_q[AW-1:AW-NSH]), .pin_o, .pin_oe_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      lp_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          lp_q <= low_pwr_i;  // mode only follows while idle
          if (req_i) begin
            if (32'(cs_sel_i) >= NCS) begin
              err_q   <= 1'b1;
              state_q <= ST_ACK;
            end else begin
              err_q   <= 1'b0;
              cs_q    <= cs_sel_i;
              addr_q  <= addr_i;
              wdata_q <= wdata_i;
              we_q    <= we_i;
              cnt_q   <= wait_w[cs_sel_i];
              state_q <= ST_ACCESS;
            end
          end
        end
        ST_ACCESS: if (tick) begin
          if (cnt_q == '0) begin
            if (!we_q) rdata_q <= pm_dq_i;
            state_q <= ST_RECOV;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RECOV: state_q <= ST_ACK;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign pm_cs_no[i] = !(busy && (cs_q == CSW'(i)));
  end

  assign pm_addr_o  = addr_q[AW-NSH-1:0];
  assign pm_oe_no   = !(busy && !we_q);
  assign pm_we_no   = !(busy && we_q);
  assign pm_dq_oe_o = busy && we_q;
  assign pm_dq_o    = wdata_q;
  assign ack_o      = (state_q == ST_ACK);
  assign err_o      = ack_o && err_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/pmem_ctrl_chk.sv
module pmem_ctrl_chk #(
  parameter int NCS = 3,
  parameter int NSH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ack_o,
  input logic           err_o,
  input logic [NCS-1:0] pm_cs_no,
  input logic           pm_oe_no,
  input logic           pm_we_no,
  input logic           pm_dq_oe_o,
  input logic [NSH-1:0] pin_oe_o
);
  p_one_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~pm_cs_no));

  p_rd_no_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pm_oe_no |-> (!pm_dq_oe_o && pm_we_no && (pm_cs_no != {NCS{1'b1}})));

  p_wr_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pm_we_no |-> (pm_dq_oe_o && pm_oe_no && (pm_cs_no != {NCS{1'b1}})));

  p_ack_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  p_gap_before_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !err_o) |-> ($past(pm_cs_no) == {NCS{1'b1}} && $past(pm_oe_no)
                           && $past(pm_we_no) && pm_cs_no == {NCS{1'b1}}));

  p_err_no_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ack_o && pm_cs_no == {NCS{1'b1}}));

  always_comb begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (pm_cs_no == {NCS{1'b1}} && pm_oe_no && pm_we_no
                               && !ack_o && pin_oe_o == '0);
    end
  end
endmodule

bind pmem_ctrl pmem_ctrl_chk #(.NCS(NCS), .NSH(NSH)) u_chk (.*);

// File: tb/sim_pmem_ctrl.sv
module sim_pmem_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic low_pwr = 0, req = 0, we = 0, cfg_we = 0;
  logic [1:0] cs_sel = 0, cfg_addr = 0, pin_in = 0;
  logic [22:0] addr = 0;
  logic [15:0] wdata = 0, dq_in = 16'hA5C3;
  logic [7:0] cfg_wdata = 0;
  logic ack, err;
  logic [15:0] rdata, dq_out;
  logic [7:0] cfg_rdata;
  logic [2:0] cs_n;
  logic [20:0] pm_addr;
  logic oe_n, we_n, dq_oe;
  logic [1:0] pin_out, pin_oe;

  int n_chk = 0, n_fail = 0;

  // snapshot of the first access cycle
  int lat, lowcnt;
  logic multi, gap_ok, r_err;
  logic [15:0] r_data, s_dq;
  logic [2:0] s_cs;
  logic s_oe, s_we, s_dqoe;
  logic [20:0] s_addr;
  logic [1:0] s_pin, s_pinoe;

  always #2.5 clk = ~clk;

  pmem_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .low_pwr_i(low_pwr), .req_i(req), .we_i(we),
    .cs_sel_i(cs_sel), .addr_i(addr), .wdata_i(wdata), .ack_o(ack), .err_o(err),
    .rdata_o(rdata), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .pm_cs_no(cs_n),
    .pm_addr_o(pm_addr), .pm_oe_no(oe_n), .pm_we_no(we_n), .pm_dq_o(dq_out),
    .pm_dq_oe_o(dq_oe), .pm_dq_i(dq_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .pin_i(pin_in)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // one access; optional config write raised in the request cycle,
  // optional mode flip after a few cycles
  task automatic access(input logic [1:0] sel, input logic w, input logic [22:0] a,
                        input logic [15:0] d, input logic col, input logic [1:0] ca,
                        input logic [7:0] cd, input logic flip);
    logic [2:0] prev;
    @(negedge clk);
    req = 1; we = w; cs_sel = sel; addr = a; wdata = d;
    if (col) begin cfg_we = 1; cfg_addr = ca; cfg_wdata = cd; end
    lat = 0; lowcnt = 0; multi = 0; gap_ok = 0; prev = 3'b111;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      cfg_we = 0;
      lat++;
      if (flip && lat == 3) low_pwr = ~low_pwr;
      if ($countones(~cs_n) > 1) multi = 1;
      if (cs_n != 3'b111) lowcnt++;
      if (lat == 1) begin
        s_cs = cs_n; s_oe = oe_n; s_we = we_n; s_dqoe = dq_oe; s_dq = dq_out;
        s_addr = pm_addr; s_pin = pin_out; s_pinoe = pin_oe;
      end
      if (ack) begin
        gap_ok = (prev == 3'b111) && (cs_n == 3'b111);
        r_err = err; r_data = rdata;
        req = 0;
        break;
      end
      prev = cs_n;
    end
    @(negedge clk);
    chk(!ack, "R6 ack single cycle", ack, 0);
  endtask

  task automatic t_reset();
    chk(cs_n == 3'b111, "R1 selects high", cs_n, 7);
    chk(oe_n && we_n, "R1 strobes high", {oe_n, we_n}, 3);
    chk(pin_oe == 2'b00, "R1 shared pins undriven", pin_oe, 0);
    chk(!ack, "R1 ack low", ack, 0);
  endtask

  task automatic t_read();
    cfg_wr(2'd0, 8'd3);
    access(2'd0, 1'b0, 23'h1ABCDE, 16'h0, 0, 0, 0, 0);
    chk(lowcnt == 4, "R4 normal cycles w=3", lowcnt, 4);
    chk(lat == 6, "R6 latency", lat, 6);
    chk(gap_ok, "R6 idle gap", gap_ok, 1);
    chk(s_cs == 3'b110, "R2 select 0 only", s_cs, 3'b110);
    chk(!s_oe && s_we && !s_dqoe, "R2 read strobes", {s_oe, s_we, s_dqoe}, 3'b010);
    chk(s_addr == 21'h1ABCDE, "R2 address", s_addr, 21'h1ABCDE);
    chk(r_data == 16'hA5C3, "R2 read data", r_data, 16'hA5C3);
    chk(!r_err, "R2 no error", r_err, 0);
  endtask

  task automatic t_write();
    cfg_wr(2'd2, 8'd0);
    access(2'd2, 1'b1, 23'h000123, 16'h5AA5, 0, 0, 0, 0);
    chk(lowcnt == 1, "R4 w=0 one cycle", lowcnt, 1);
    chk(s_cs == 3'b011, "R3 select 2", s_cs, 3'b011);
    chk(!s_we && s_oe && s_dqoe, "R3 write strobes", {s_oe, s_we, s_dqoe}, 3'b101);
    chk(s_dq == 16'h5AA5, "R3 write data", s_dq, 16'h5AA5);
    chk(!multi, "R7 single select", multi, 0);
  endtask

  task automatic t_per_cs();
    cfg_wr(2'd1, 8'd31);
    access(2'd1, 1'b0, 23'h0, 16'h0, 0, 0, 0, 0);
    chk(lowcnt == 32, "R5 select 1 w=31", lowcnt, 32);
    chk(s_cs == 3'b101, "R5 boot select", s_cs, 3'b101);
    access(2'd0, 1'b0, 23'h0, 16'h0, 0, 0, 0, 0);
    chk(lowcnt == 4, "R5 select 0 unaffected", lowcnt, 4);
    @(negedge clk); cfg_addr = 2'd1; #1;
    chk(cfg_rdata == 8'd31, "R5 readback", cfg_rdata, 31);
  endtask

  task automatic t_lowpwr();
    cfg_wr(2'd0, 8'd2);
    low_pwr = 1;
    access(2'd0, 1'b0, 23'h0, 16'h0, 0, 0, 0, 1);
    chk(lowcnt == 24, "R11 low power kept after flip", lowcnt, 24);
    chk(lat == 26, "R4 low power latency", lat, 26);
    chk(!multi, "R7 single select low power", multi, 0);
    access(2'd0, 1'b0, 23'h0, 16'h0, 0, 0, 0, 0);
    chk(lowcnt == 3, "R11 normal after idle", lowcnt, 3);
    low_pwr = 1;
    access(2'd0, 1'b0, 23'h0, 16'h0, 0, 0, 0, 0);
    chk(lowcnt == 24, "R4 low power w=2", lowcnt, 24);
    low_pwr = 0;
  endtask

  task automatic t_err();
    access(2'd3, 1'b0, 23'h0, 16'h0, 0, 0, 0, 0);
    chk(lat == 1, "R8 error latency", lat, 1);
    chk(r_err, "R8 error flag", r_err, 1);
    chk(lowcnt == 0, "R8 no select", lowcnt, 0);
  endtask

  task automatic t_gpio();
    cfg_wr(2'd3, 8'b00_01_01_00);  // pin21 driven, value 1
    #1;
    chk(pin_oe == 2'b01, "R9 gpio enable", pin_oe, 1);
    chk(pin_out[0], "R9 gpio value", pin_out, 1);
    access(2'd0, 1'b0, 23'h000000, 16'h0, 0, 0, 0, 0);
    chk(s_pin[0] == 1'b1 && s_pinoe == 2'b01, "R9 address ignored", {s_pinoe, s_pin}, 4'b0101);
    pin_in = 2'b10;
    @(negedge clk); cfg_addr = 2'd3; #1;
    chk(cfg_rdata[7:6] == 2'b10, "R12 pin input readback", cfg_rdata[7:6], 2);
  endtask

  task automatic t_addr_mode();
    cfg_wr(2'd3, 8'b00_00_00_11);
    access(2'd0, 1'b0, 23'h400000, 16'h0, 0, 0, 0, 0);
    chk(s_pin == 2'b10, "R10 upper address on pins", s_pin, 2);
    chk(s_pinoe == 2'b11, "R10 pins driven", s_pinoe, 3);
    access(2'd0, 1'b0, 23'h200000, 16'h0, 0, 0, 0, 0);
    chk(s_pin == 2'b01, "R10 bit 21 on pin", s_pin, 1);
  endtask

  task automatic t_collide();
    cfg_wr(2'd0, 8'd2);
    access(2'd0, 1'b0, 23'h0, 16'h0, 1, 2'd0, 8'd5, 0);
    chk(lowcnt == 3, "R5 old count on collision", lowcnt, 3);
    access(2'd0, 1'b0, 23'h0, 16'h0, 0, 0, 0, 0);
    chk(lowcnt == 6, "R5 new count next access", lowcnt, 6);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    #10 rst_n = 1;
    t_read();
    t_write();
    t_per_cs();
    t_lowpwr();
    t_err();
    t_gpio();
    t_addr_mode();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule